// File: doc/BRIEF.md
# I2C Slave Transmitter with Status Codes

This block is a byte-oriented I2C target that answers when a bus master addresses it and returns data bytes on read transfers. It samples SCL and SDA and pulls them low through open-drain enables. Software sets it up through plain control inputs: a 7-bit own address, a general-call enable, an acknowledge enable and a module enable. After each bus event the block raises a flag, holds SCL low and publishes an 8-bit status code. Software answers by loading the next byte and writing a one to the flag-clear input, which releases the clock.

Read transfers are served byte by byte. When the acknowledge enable is low at the moment a byte is committed, that byte is the final one. After it goes out the block detaches from the bus until the next START. Write transfers are recognised, acknowledged and reported, but their data is not taken in. A START or STOP seen mid-transfer returns the block to address recognition.

Top module: `i2c_tx_slave`

## Requirements
- R1: After reset the flag is low, the status reads 0xF8, and neither SCL nor SDA is pulled low.
- R2: With the module and acknowledge enables high, an address byte whose upper seven bits equal the own address and whose bit 0 (direction) is 1 is acknowledged with SDA low during the ninth clock. After that clock's falling edge the flag rises with status 0xA8.
- R3: An address byte that matches neither the own address nor an enabled general call is not acknowledged: SDA stays released in the ninth clock and the flag stays low. The same holds for the own address while the acknowledge enable is low, and recognition resumes as soon as it is set again.
- R4: Address 0x00 with direction 0 (general call) is acknowledged with status 0x70 only while the general-call enable is high; otherwise it is ignored.
- R5: Own address with direction 0 is acknowledged with status 0x60. After the flag is cleared the block releases the bus and does not acknowledge the following data byte.
- R6: Data bytes go out MSB first, and SDA is changed only while SCL is low.
- R7: While the flag is high, SCL is held low. The flag stays high until flag-clear is pulsed, which resumes the transfer.
- R8: After a data byte that is not the last one, status is 0xB8 if the master acknowledged and 0xC0 if it did not.
- R9: A byte committed while the acknowledge enable is low is the last byte. After it, status is 0xC8 on master ACK or 0xC0 on NACK. SDA is then released, so further bytes read as 0xFF and raise no flag.
- R10: A STOP or a repeated START in the middle of an address byte returns the block to address recognition, and the next complete address is served normally.
- R11: The status output reads 0xF8 whenever the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; low forces idle and clears the flag |
| own_addr | input | 7 | Own 7-bit bus address |
| gc_en | input | 1 | Answer the general call address |
| ack_en | input | 1 | Acknowledge enable; low marks the next byte as last and blocks address matching |
| tx_data | input | 8 | Next byte to transmit |
| tx_load | input | 1 | Writes tx_data into the holding register |
| flag_clr | input | 1 | Pulse to clear the flag and resume |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| flag | output | 1 | Event flag |
| status | output | 8 | Status code |

## Verification
The assertions assume the master keeps each SCL level for several system clocks and changes SDA only while SCL is low, except when it forms a START or STOP. They also assume software does not load a new byte in the same cycle it clears the flag. The bench master waits a dozen cycles in every bus phase and waits for SCL to read high before it counts its high time, so it honours stretching. The software model loads data, then adjusts the acknowledge enable, then pulses flag-clear, each in a separate cycle.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_WAIT, S_TX, S_ACKCHK
    } ctl_state_e;

    localparam logic [7:0] CODE_RD_ADDR  = 8'hA8;
    localparam logic [7:0] CODE_WR_ADDR  = 8'h60;
    localparam logic [7:0] CODE_GC_ADDR  = 8'h70;
    localparam logic [7:0] CODE_TX_ACK   = 8'hB8;
    localparam logic [7:0] CODE_TX_NACK  = 8'hC0;
    localparam logic [7:0] CODE_LAST_ACK = 8'hC8;
    localparam logic [7:0] CODE_NONE     = 8'hF8;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic scl;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] got, input logic rw,
                                      input logic [ADDR_W-1:0] own, input logic gc_on);
        return (got == own) || (gc_on && got == '0 && !rw);
    endfunction

    function automatic logic code_known(input logic [7:0] c);
        return c inside {CODE_RD_ADDR, CODE_WR_ADDR, CODE_GC_ADDR, CODE_TX_ACK,
                         CODE_TX_NACK, CODE_LAST_ACK};
    endfunction
endpackage

// File: rtl/i2cst_linemon.sv
module i2cst_linemon
    import i2cst_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q, sda_q, scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    always_comb begin
        ev.rise  = scl_q & ~scl_p;
        ev.fall  = ~scl_q & scl_p;
        ev.start = scl_q & scl_p & sda_p & ~sda_q;
        ev.stop  = scl_q & scl_p & ~sda_p & sda_q;
        ev.scl   = scl_q;
        ev.sda   = sda_q;
    end
endmodule

// File: rtl/i2cst_txshift.sv
module i2cst_txshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] hold_q, sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            sh_q   <= '1;
        end else begin
            if (wr) hold_q <= wdata;
            if (load) sh_q <= hold_q;
            else if (shift) sh_q <= {sh_q[W-2:0], 1'b1};
        end
    end

    assign msb = sh_q[W-1];

    // R6: the first bit driven after a load is the held byte's MSB
    p_load_msb_r6: assert property (@(posedge clk) disable iff (rst)
        load && !wr |=> msb == $past(hold_q[W-1]));
endmodule

// File: rtl/i2cst_ctrl.sv
module i2cst_ctrl
    import i2cst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ack_en,
    input  logic              gc_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  bus_ev_t           ev,
    input  logic              flag_clr,
    input  logic              msb,
    output logic              load,
    output logic              shift,
    output logic              sda_oe,
    output logic              flag,
    output logic [7:0]        code
);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

    ctl_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sr_q;
    logic drive_q, flag_q, more_q, last_q, ack_q, gc_q, rd_q;
    logic [7:0] code_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            sr_q    <= '0;
            drive_q <= 1'b0;
            flag_q  <= 1'b0;
            more_q  <= 1'b0;
            last_q  <= 1'b0;
            ack_q   <= 1'b0;
            gc_q    <= 1'b0;
            rd_q    <= 1'b0;
            code_q  <= CODE_NONE;
        end else if (!flag_q && ev.start) begin
            state_q <= S_ADDR;
            cnt_q   <= '0;
            drive_q <= 1'b0;
        end else if (!flag_q && ev.stop) begin
            state_q <= S_IDLE;
            drive_q <= 1'b0;
        end else begin
            case (state_q)
                S_ADDR: if (ev.rise) begin
                    sr_q <= {sr_q[BYTE_W-2:0], ev.sda};
                    if (cnt_q == BIT_LAST) begin
                        cnt_q   <= '0;
                        rd_q    <= ev.sda;
                        gc_q    <= (sr_q[ADDR_W-1:0] == '0);
                        state_q <= (ack_en && addr_hit(sr_q[ADDR_W-1:0], ev.sda, own_addr, gc_en))
                                   ? S_AACK : S_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_AACK: if (ev.fall) begin
                    if (cnt_q == '0) begin
                        drive_q <= 1'b1;
                        cnt_q   <= 1;
                    end else begin
                        drive_q <= 1'b0;
                        flag_q  <= 1'b1;
                        more_q  <= rd_q;
                        state_q <= S_WAIT;
                        code_q  <= rd_q ? CODE_RD_ADDR : (gc_q ? CODE_GC_ADDR : CODE_WR_ADDR);
                    end
                end
                S_WAIT: if (flag_clr) begin
                    flag_q <= 1'b0;
                    cnt_q  <= '0;
                    if (more_q) begin
                        last_q  <= !ack_en;
                        state_q <= S_TX;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                S_TX: if (ev.fall) begin
                    if (cnt_q == BIT_LAST) begin
                        cnt_q   <= '0;
                        state_q <= S_ACKCHK;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_ACKCHK: if (ev.rise) begin
                    ack_q <= !ev.sda;
                    cnt_q <= 1;
                end else if (ev.fall && cnt_q == 1) begin
                    flag_q  <= 1'b1;
                    state_q <= S_WAIT;
                    more_q  <= ack_q && !last_q;
                    code_q  <= !ack_q ? CODE_TX_NACK : (last_q ? CODE_LAST_ACK : CODE_TX_ACK);
                end
                default: ;
            endcase
        end
    end

    assign load   = (state_q == S_WAIT) && flag_clr && more_q;
    assign shift  = (state_q == S_TX) && ev.fall;
    assign sda_oe = drive_q | ((state_q == S_TX) && !msb);
    assign flag   = flag_q;
    assign code   = code_q;

    // R7: a new event is only posted right after an SCL falling edge
    p_flag_after_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(ev.fall));
    // R3: nothing is driven while not addressed
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        state_q == S_IDLE |-> !sda_oe);
    // R8: the master's acknowledge bit is never overdriven
    p_ack_released_r8: assert property (@(posedge clk) disable iff (rst)
        state_q == S_ACKCHK |-> !sda_oe);
    // R11: a raised flag always carries a defined code
    p_code_known_r11: assert property (@(posedge clk) disable iff (rst)
        flag_q |-> code_known(code_q));
    // R6: SDA drive changes only during the SCL low phase
    p_sda_low_phase_r6: assert property (@(posedge clk) disable iff (rst)
        en && $past(en) && !$stable(sda_oe) |-> !ev.scl);
endmodule

// File: rtl/i2c_tx_slave.sv
module i2c_tx_slave
    import i2cst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic              flag_clr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              flag,
    output logic [7:0]        status
);
    bus_ev_t    ev;
    logic       load, shift, msb;
    logic [7:0] code;

    i2cst_linemon u_mon (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2cst_txshift #(.W(BYTE_W)) u_sh (
        .clk(clk), .rst(rst), .wr(tx_load), .wdata(tx_data),
        .load(load), .shift(shift), .msb(msb)
    );

    i2cst_ctrl u_ctl (
        .clk(clk), .rst(rst), .en(en), .ack_en(ack_en), .gc_en(gc_en),
        .own_addr(own_addr), .ev(ev), .flag_clr(flag_clr), .msb(msb),
        .load(load), .shift(shift), .sda_oe(sda_oe), .flag(flag), .code(code)
    );

    assign scl_oe = flag;
    assign status = flag ? code : CODE_NONE;
endmodule

// File: tb/sim_i2c_tx_slave.sv
module sim_i2c_tx_slave;
    localparam int H = 12;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic en = 1'b0, ack_drv = 1'b0, ack_sw = 1'b1, gc_en = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_load = 1'b0, flag_clr = 1'b0;
    logic scl_oe, sda_oe, flag;
    logic [7:0] status;
    logic scl_line, sda_line, ack_ctl;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;
    assign ack_ctl  = ack_drv & ack_sw;

    i2c_tx_slave u0 (
        .clk(clk), .rst(rst), .en(en), .own_addr(OWN), .gc_en(gc_en),
        .ack_en(ack_ctl), .tx_data(tx_data), .tx_load(tx_load), .flag_clr(flag_clr),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .flag(flag), .status(status)
    );

    int n_run = 0, n_fail = 0, n_flags = 0, f0 = 0;
    logic       a;
    logic [7:0] v;

    logic [7:0] q_code[$];
    logic [7:0] q_data[$];
    logic       q_ack[$];
    string      q_req[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] c, input logic [7:0] d, input logic ak, input string req);
        q_code.push_back(c);
        q_data.push_back(d);
        q_ack.push_back(ak);
        q_req.push_back(req);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        hw(H);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hw(H);
        scl_up();
        m_sda = 1'b0; hw(H);
        m_scl = 1'b0; hw(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hw(H);
        scl_up();
        m_sda = 1'b1; hw(H);
    endtask

    task automatic wbit(input logic b);
        m_sda = b; hw(H);
        scl_up();
        m_scl = 1'b0; hw(2);
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; hw(H);
        scl_up();
        b = sda_line;
        m_scl = 1'b0; hw(2);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        acked = !b;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) rbit(d[i]);
        wbit(!give_ack);
    endtask

    // monitor: software model and scoreboard of status codes
    initial begin
        forever begin
            @(negedge clk);
            if (flag) begin
                n_flags++;
                if (q_code.size() == 0) begin
                    chk("unexpected flag", {24'h0, status}, 32'h0);
                end else begin
                    logic [7:0] ec, ed;
                    logic       ea;
                    string      er;
                    ec = q_code.pop_front();
                    ed = q_data.pop_front();
                    ea = q_ack.pop_front();
                    er = q_req.pop_front();
                    chk(er, {24'h0, status}, {24'h0, ec});
                    hw(3);
                    chk({er, " R7 scl held"}, {31'h0, scl_line}, 32'h0);
                    tx_data = ed; tx_load = 1'b1; hw(1); tx_load = 1'b0;
                    ack_sw = ea; hw(H);
                    chk({er, " R7 flag held"}, {31'h0, flag}, 32'h1);
                end
                flag_clr = 1'b1; hw(1); flag_clr = 1'b0; hw(1);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // driver
    initial begin
        hw(5);
        chk("R1 flag", {31'h0, flag}, 32'h0);
        chk("R1 status", {24'h0, status}, 32'hF8);
        chk("R1 sda_oe", {31'h0, sda_oe}, 32'h0);
        chk("R1 scl_oe", {31'h0, scl_oe}, 32'h0);
        rst = 1'b0; en = 1'b1; ack_drv = 1'b1;
        hw(5);

        // R2 / R6 / R8: two bytes, ACK then NACK
        push(8'hA8, 8'hA5, 1'b1, "R2 read addr");
        push(8'hB8, 8'h3C, 1'b1, "R8 ack");
        push(8'hC0, 8'h00, 1'b1, "R8 nack");
        bus_start();
        wbyte({OWN, 1'b1}, a); chk("R2 addr ack", {31'h0, a}, 32'h1);
        rbyte(1'b1, v); chk("R6 byte0", {24'h0, v}, 32'hA5);
        rbyte(1'b0, v); chk("R6 byte1", {24'h0, v}, 32'h3C);
        bus_stop();
        chk("R11 idle status", {24'h0, status}, 32'hF8);

        // R9: last byte with master ACK
        push(8'hA8, 8'h81, 1'b0, "R9 addr");
        push(8'hC8, 8'h00, 1'b1, "R9 last ack");
        bus_start();
        wbyte({OWN, 1'b1}, a);
        rbyte(1'b1, v); chk("R9 last byte", {24'h0, v}, 32'h81);
        f0 = n_flags;
        rbyte(1'b1, v); chk("R9 released reads ones", {24'h0, v}, 32'hFF);
        chk("R9 no flag after last", n_flags - f0, 0);
        bus_stop();

        // R9: last byte with master NACK
        push(8'hA8, 8'h5E, 1'b0, "R9 addr2");
        push(8'hC0, 8'h00, 1'b1, "R9 last nack");
        bus_start();
        wbyte({OWN, 1'b1}, a);
        rbyte(1'b0, v); chk("R9 last byte2", {24'h0, v}, 32'h5E);
        bus_stop();

        // R3: foreign address, then ack_en low, then resume
        f0 = n_flags;
        bus_start(); wbyte({7'h15, 1'b1}, a); bus_stop();
        chk("R3 foreign nack", {31'h0, a}, 32'h0);
        ack_drv = 1'b0;
        bus_start(); wbyte({OWN, 1'b1}, a); bus_stop();
        chk("R3 ack_en low nack", {31'h0, a}, 32'h0);
        chk("R3 no flag", n_flags - f0, 0);
        ack_drv = 1'b1;
        push(8'hA8, 8'h77, 1'b1, "R3 resume");
        push(8'hC0, 8'h00, 1'b1, "R3 resume end");
        bus_start(); wbyte({OWN, 1'b1}, a);
        chk("R3 resume ack", {31'h0, a}, 32'h1);
        rbyte(1'b0, v); chk("R3 resume data", {24'h0, v}, 32'h77);
        bus_stop();

        // R4: general call off then on
        f0 = n_flags;
        bus_start(); wbyte(8'h00, a); bus_stop();
        chk("R4 gc ignored", {31'h0, a}, 32'h0);
        chk("R4 gc no flag", n_flags - f0, 0);
        gc_en = 1'b1;
        push(8'h70, 8'h00, 1'b1, "R4 gc status");
        bus_start(); wbyte(8'h00, a);
        chk("R4 gc ack", {31'h0, a}, 32'h1);
        wbyte(8'h55, a); chk("R4 gc data not acked", {31'h0, a}, 32'h0);
        bus_stop();
        gc_en = 1'b0;

        // R5: own address write
        push(8'h60, 8'h00, 1'b1, "R5 write addr");
        bus_start(); wbyte({OWN, 1'b0}, a);
        chk("R5 addr ack", {31'h0, a}, 32'h1);
        f0 = n_flags;
        wbyte(8'hAA, a); chk("R5 data ignored", {31'h0, a}, 32'h0);
        chk("R5 no flag", n_flags - f0, 0);
        bus_stop();

        // R10: STOP mid address, then a normal read
        bus_start();
        for (int i = 6; i >= 3; i--) wbit(OWN[i]);
        bus_stop();
        push(8'hA8, 8'h99, 1'b1, "R10 after stop");
        push(8'hC0, 8'h00, 1'b1, "R10 end1");
        bus_start(); wbyte({OWN, 1'b1}, a);
        rbyte(1'b0, v); chk("R10 data after stop", {24'h0, v}, 32'h99);
        bus_stop();

        // R10: repeated START mid address
        push(8'hA8, 8'h42, 1'b1, "R10 after rstart");
        push(8'hC0, 8'h00, 1'b1, "R10 end2");
        bus_start();
        for (int i = 6; i >= 4; i--) wbit(OWN[i]);
        bus_start();
        wbyte({OWN, 1'b1}, a); chk("R10 rstart ack", {31'h0, a}, 32'h1);
        rbyte(1'b0, v); chk("R10 data after rstart", {24'h0, v}, 32'h42);
        bus_stop();

        hw(20);
        chk("scoreboard drained", q_code.size(), 0);
        chk("R11 final status", {24'h0, status}, 32'hF8);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule